// File: doc/BRIEF.md
# Coefficient ROM Boot Sequencer

This block sits on the master side of a group of filter devices that share one byte-wide coefficient ROM. When its reset input is released it walks through the ROM one device block at a time. For each block it reads a 16-bit control word and then as many coefficient words as that control word's length field calls for. The master's own block is always block zero. For that block the sequencer assembles byte pairs into words and writes its local control register and coefficient memory. For the other blocks it only drives the shared address lines and pulses a strobe. Each slave compares the broadcast block number with its own hard-wired code and captures the byte on the strobe, so no address decoder is needed outside the devices.

Every ROM address is held for a fixed slot of clock cycles so that the ROM has time to respond. `busy` stays high from reset release until the last byte of the last block has been taken. After that the filter run flag is set either by the free-run input or by a fresh rising edge of the filter-enable input.

Top module: `coef_rom_loader`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `rom_addr` is 0, `ctl_sel` is 1, `blk_addr` is 0, `ctrl_reg` is 0, and `run`, `coef_we` and `slave_we` are 0.
- R2: A new ROM transfer starts at reset release and then every 4 clock cycles. `rom_addr`, `ctl_sel` and `blk_addr` stay constant for the 4 cycles of a transfer.
- R3: Bytes are read low byte first. `rom_addr` bit 0 = 0 selects the low byte and bit 0 = 1 the high byte. The low byte is staged. One cycle after the high-byte transfer ends, `coef_we` pulses for one cycle with `coef_wdata` = {high, low} and `coef_waddr` = `rom_addr` >> 1.
- R4: Each block begins with two transfers at addresses 0 and 1 with `ctl_sel` = 1, which fetch the control word. `ctl_sel` is 0 for all of that block's coefficient transfers.
- R5: Bits [14:13] of a block's control word set its coefficient count: 00 gives 32 words, 01 gives 64 and 1x gives 128. Coefficient addresses run from 0 to twice the count minus 1, so unused high address bits stay 0.
- R6: Blocks are visited in the order 0, 1, …, `slave_count`. `slave_we` is 1 only in the fourth cycle of each transfer of a nonzero block. Nonzero blocks never cause `coef_we` or `ctrl_reg` updates.
- R7: `busy` falls exactly 4·N cycles after reset release, where N is the total number of transfers. It then stays low until the next reset. After the sequence the address outputs hold the last transfer's values.
- R8: `ctrl_reg` takes block 0's control word one cycle after its high byte is read, that is 8 cycles after release, and keeps it.
- R9: `run` rises only after `busy` has fallen. With `free_run` high it rises one cycle after the first low-`busy` cycle. Otherwise it needs `fen` sampled low and then high at consecutive clock edges. A level held high across the end of the load does not count.
- R10: Asserting `rst_n` in the middle of a load aborts it. On release the sequence restarts from block 0, address 0, control phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release starts a load |
| slave_count | input | 4 | Number of slave blocks to load after block 0 |
| rom_data | input | 8 | Byte returned by the ROM |
| fen | input | 1 | Filter enable; a rising edge starts filtering |
| free_run | input | 1 | Start filtering as soon as the load ends |
| rom_addr | output | 8 | Low ROM address; bit 0 is the byte select |
| ctl_sel | output | 1 | ROM address bit above `rom_addr`: 1 for control word, 0 for coefficients |
| blk_addr | output | 4 | Device block address broadcast to ROM and slaves |
| slave_we | output | 1 | Byte strobe for slaves |
| busy | output | 1 | Load sequence in progress |
| ctrl_reg | output | 16 | Local control register |
| coef_we | output | 1 | Local coefficient memory write |
| coef_waddr | output | 7 | Local coefficient index |
| coef_wdata | output | 16 | Local coefficient word |
| run | output | 1 | Filter running |

## Verification
The hardest situation to reach is a reset that lands partway through a long block whose length comes from the ROM's own control word, followed by a clean restart. The bench runs a 128-word master block, pulls reset about 75 transfers in, and then follows the repeated sequence cycle by cycle. A second difficult case is the start condition after the load. The bench holds `fen` high through an entire multi-block load to show that the level alone does not start the filter. It then drops and raises `fen` to produce a genuine edge.

// File: rtl/coef_ldr_pkg.sv
package coef_ldr_pkg;
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_IDLE  = 1'b1
    } phase_e;

    localparam int LEN_CODE_W = 2;
endpackage

// File: rtl/coef_slot_timer.sv
module coef_slot_timer #(
    parameter int SLOT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic slot_last
);
    localparam int CW = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run_en) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slot_last = run_en && (cnt_q == LAST);
endmodule

// File: rtl/coef_byte_stager.sv
module coef_byte_stager #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] staged
);
    logic [BYTE_W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (cap) stage_d = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign staged = stage_q;
endmodule

// File: rtl/coef_len_decode.sv
module coef_len_decode import coef_ldr_pkg::*; #(
    parameter int ADDR_W = 8
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    output logic [ADDR_W-1:0]     last_idx
);
    localparam int BYTE_SPAN = 1 << ADDR_W;

    always_comb begin
        case (len_code)
            2'b00:   last_idx = ADDR_W'((BYTE_SPAN >> 2) - 1);
            2'b01:   last_idx = ADDR_W'((BYTE_SPAN >> 1) - 1);
            default: last_idx = ADDR_W'(BYTE_SPAN - 1);
        endcase
    end
endmodule

// File: rtl/coef_rom_loader.sv
module coef_rom_loader import coef_ldr_pkg::*; #(
    parameter int ADDR_W   = 8,
    parameter int BLK_W    = 4,
    parameter int WORD_W   = 16,
    parameter int SLOT_CYC = 4,
    parameter int LEN_LSB  = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BLK_W-1:0]    slave_count,
    input  logic [WORD_W/2-1:0] rom_data,
    input  logic                fen,
    input  logic                free_run,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic                ctl_sel,
    output logic [BLK_W-1:0]    blk_addr,
    output logic                slave_we,
    output logic                busy,
    output logic [WORD_W-1:0]   ctrl_reg,
    output logic                coef_we,
    output logic [ADDR_W-2:0]   coef_waddr,
    output logic [WORD_W-1:0]   coef_wdata,
    output logic                run
);
    localparam int BYTE_W  = WORD_W / 2;
    localparam int LEN_POS = LEN_LSB - BYTE_W;

    typedef struct packed {
        phase_e              phase;
        logic [BLK_W-1:0]    blk;
        logic                ctl;
        logic [ADDR_W-1:0]   idx;
        logic [ADDR_W-1:0]   last;
        logic                busy;
        logic                run;
        logic                fen_prev;
        logic [WORD_W-1:0]   ctrl;
        logic                cwe;
        logic [ADDR_W-2:0]   cwaddr;
        logic [WORD_W-1:0]   cwdata;
    } st_t;

    localparam st_t ST_RESET = '{
        phase: PH_FETCH, blk: '0, ctl: 1'b1, idx: '0, last: '0,
        busy: 1'b1, run: 1'b0, fen_prev: 1'b0, ctrl: '0,
        cwe: 1'b0, cwaddr: '0, cwdata: '0
    };

    st_t q, d;
    logic slot_last;
    logic cap_lo;
    logic [BYTE_W-1:0] staged;
    logic [ADDR_W-1:0] last_dec;
    logic [WORD_W-1:0] word;

    coef_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (q.busy),
        .slot_last (slot_last)
    );

    assign cap_lo = (q.phase == PH_FETCH) && slot_last && !q.idx[0];

    coef_byte_stager #(.BYTE_W(BYTE_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap_lo),
        .byte_in (rom_data),
        .staged  (staged)
    );

    coef_len_decode #(.ADDR_W(ADDR_W)) u_len (
        .len_code (rom_data[LEN_POS +: LEN_CODE_W]),
        .last_idx (last_dec)
    );

    assign word = {rom_data, staged};

    always_comb begin
        d          = q;
        d.cwe      = 1'b0;
        d.fen_prev = fen;
        if (q.phase == PH_FETCH) begin
            if (slot_last) begin
                if (q.ctl) begin
                    if (q.idx[0]) begin
                        if (q.blk == '0) d.ctrl = word;
                        d.last = last_dec;
                        d.ctl  = 1'b0;
                        d.idx  = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end else begin
                    if (q.idx[0] && q.blk == '0) begin
                        d.cwe    = 1'b1;
                        d.cwaddr = q.idx[ADDR_W-1:1];
                        d.cwdata = word;
                    end
                    if (q.idx == q.last) begin
                        if (q.blk == slave_count) begin
                            d.phase = PH_IDLE;
                            d.busy  = 1'b0;
                        end else begin
                            d.blk = q.blk + 1'b1;
                            d.ctl = 1'b1;
                            d.idx = '0;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
        end else begin
            if (!q.run && (free_run || (fen && !q.fen_prev))) d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RESET;
        else        q <= d;
    end

    assign rom_addr   = q.idx;
    assign ctl_sel    = q.ctl;
    assign blk_addr   = q.blk;
    assign busy       = q.busy;
    assign slave_we   = slot_last && (q.blk != '0);
    assign ctrl_reg   = q.ctrl;
    assign coef_we    = q.cwe;
    assign coef_waddr = q.cwaddr;
    assign coef_wdata = q.cwdata;
    assign run        = q.run;
endmodule

// File: rtl/coef_rom_loader_chk.sv
module coef_rom_loader_chk #(
    parameter int ADDR_W   = 8,
    parameter int BLK_W    = 4,
    parameter int SLOT_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              ctl_sel,
    input logic [BLK_W-1:0]  blk_addr,
    input logic              slave_we,
    input logic              coef_we,
    input logic              run
);
    localparam int CW = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (busy) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assert_rst_state_R1: assert property (@(posedge clk)
        !rst_n |-> (busy && ctl_sel && rom_addr == '0 && blk_addr == '0
                    && !run && !coef_we && !slave_we));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |-> ($stable(rom_addr) && $stable(ctl_sel) && $stable(blk_addr)));

    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |=> !coef_we);

    assert_sel_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel |-> (rom_addr[ADDR_W-1:1] == '0));

    assert_slave_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slave_we |-> (busy && blk_addr != '0 && cnt == LAST));

    assert_busy_stays_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    assert_run_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !busy);
endmodule

bind coef_rom_loader coef_rom_loader_chk #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .SLOT_CYC (SLOT_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rom_addr (rom_addr),
    .ctl_sel  (ctl_sel),
    .blk_addr (blk_addr),
    .slave_we (slave_we),
    .coef_we  (coef_we),
    .run      (run)
);

// File: tb/coef_rom_loader_tb.sv
module coef_rom_loader_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [3:0]  slave_count = '0;
    logic [7:0]  rom_data;
    logic        fen = 1'b0;
    logic        free_run = 1'b0;
    logic [7:0]  rom_addr;
    logic        ctl_sel;
    logic [3:0]  blk_addr;
    logic        slave_we;
    logic        busy;
    logic [15:0] ctrl_reg;
    logic        coef_we;
    logic [6:0]  coef_waddr;
    logic [15:0] coef_wdata;
    logic        run;

    coef_rom_loader u_dut (
        .clk(clk), .rst_n(rst_n), .slave_count(slave_count), .rom_data(rom_data),
        .fen(fen), .free_run(free_run), .rom_addr(rom_addr), .ctl_sel(ctl_sel),
        .blk_addr(blk_addr), .slave_we(slave_we), .busy(busy), .ctrl_reg(ctrl_reg),
        .coef_we(coef_we), .coef_waddr(coef_waddr), .coef_wdata(coef_wdata), .run(run)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int modes [16];
    int q_blk [$];
    int q_ctl [$];
    int q_addr [$];
    int n_tr;
    int n;
    int master_word;
    int prev_addr;
    bit run_m;
    bit fenp_m;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] rom_byte(int b, int c, int a);
        if (c != 0) begin
            if (a % 2 == 0) return 8'h80;
            return 8'(128 + (modes[b] & 3) * 32 + 5);
        end
        return 8'((b * 37 + a * 5 + 3) & 255);
    endfunction

    always_comb rom_data = rom_byte(int'(blk_addr), int'(ctl_sel), int'(rom_addr));

    function automatic int ncoef(int m);
        if (m == 0) return 32;
        if (m == 1) return 64;
        return 128;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, n, act, exp);
        end
    endtask

    task automatic build(int slaves);
        q_blk.delete(); q_ctl.delete(); q_addr.delete();
        for (int b = 0; b <= slaves; b++) begin
            for (int a = 0; a < 2; a++) begin
                q_blk.push_back(b); q_ctl.push_back(1); q_addr.push_back(a);
            end
            for (int a = 0; a < 2 * ncoef(modes[b]); a++) begin
                q_blk.push_back(b); q_ctl.push_back(0); q_addr.push_back(a);
            end
        end
        n_tr = q_blk.size();
        master_word = int'(rom_byte(0, 1, 1)) * 256 + int'(rom_byte(0, 1, 0));
        slave_count = 4'(slaves);
    endtask

    task automatic compare();
        bit exp_busy;
        int p;
        int pp;
        bit exp_we;
        exp_busy = (n < 4 * n_tr);
        p = exp_busy ? n / 4 : n_tr - 1;
        chk(busy == exp_busy, "R7", "busy", busy, exp_busy);
        if (q_ctl[p] != 0) chk(int'(rom_addr) == q_addr[p], "R4", "control address", rom_addr, q_addr[p]);
        else               chk(int'(rom_addr) == q_addr[p], "R5", "coefficient address", rom_addr, q_addr[p]);
        chk(int'(ctl_sel) == q_ctl[p], "R4", "ctl_sel", ctl_sel, q_ctl[p]);
        chk(int'(blk_addr) == q_blk[p], "R6", "blk_addr", blk_addr, q_blk[p]);
        if (exp_busy && (n % 4 != 0))
            chk(int'(rom_addr) == prev_addr, "R2", "address hold", rom_addr, prev_addr);
        prev_addr = int'(rom_addr);
        chk(slave_we == (exp_busy && n % 4 == 3 && q_blk[p] != 0), "R6", "slave_we",
            slave_we, (exp_busy && n % 4 == 3 && q_blk[p] != 0));
        exp_we = 1'b0;
        pp = 0;
        if (n > 0 && n % 4 == 0 && n / 4 - 1 < n_tr) begin
            pp = n / 4 - 1;
            if (q_blk[pp] == 0 && q_ctl[pp] == 0 && q_addr[pp] % 2 == 1) exp_we = 1'b1;
        end
        chk(coef_we == exp_we, "R3", "coef_we", coef_we, exp_we);
        if (exp_we) begin
            chk(int'(coef_waddr) == q_addr[pp] / 2, "R3", "coef_waddr", coef_waddr, q_addr[pp] / 2);
            chk(coef_wdata == {rom_byte(0, 0, q_addr[pp]), rom_byte(0, 0, q_addr[pp] - 1)}, "R3",
                "coef_wdata", coef_wdata, {rom_byte(0, 0, q_addr[pp]), rom_byte(0, 0, q_addr[pp] - 1)});
        end
        chk(int'(ctrl_reg) == ((n >= 8) ? master_word : 0), "R8", "ctrl_reg",
            ctrl_reg, (n >= 8) ? master_word : 0);
        chk(run == run_m, "R9", "run", run, run_m);
    endtask

    task automatic step(bit fen_v, bit fr_v);
        @(negedge clk);
        if (!run_m && n >= 4 * n_tr && (free_run || (fen && !fenp_m))) run_m = 1'b1;
        fenp_m = fen;
        n++;
        compare();
        fen = fen_v;
        free_run = fr_v;
    endtask

    task automatic do_reset(bit fen_v, bit fr_v);
        @(negedge clk);
        rst_n = 1'b0;
        fen = 1'b0;
        free_run = 1'b0;
        @(negedge clk);
        chk(busy && ctl_sel && rom_addr == 0 && blk_addr == 0 && ctrl_reg == 0
            && !run && !coef_we && !slave_we, "R1", "reset state",
            {busy, ctl_sel, run, coef_we, slave_we}, 5'b11000);
        rst_n = 1'b1;
        n = 0;
        run_m = 1'b0;
        fenp_m = 1'b0;
        prev_addr = 0;
        compare();
        fen = fen_v;
        free_run = fr_v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) modes[i] = 0;
        #1 rst_n = 1'b0;

        // Master only, 32 words, free-run start (R5, R7, R9)
        modes[0] = 0;
        build(0);
        do_reset(1'b0, 1'b1);
        repeat (4 * n_tr + 6) step(1'b0, 1'b1);
        chk(run == 1'b1, "R9", "free-run start", run, 1);

        // Master + two slaves, fen level held high over the load (R6, R9)
        modes[0] = 1; modes[1] = 0; modes[2] = 2;
        build(2);
        do_reset(1'b1, 1'b0);
        repeat (4 * n_tr + 10) step(1'b1, 1'b0);
        chk(run == 1'b0, "R9", "held fen level ignored", run, 0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk(run == 1'b1, "R9", "fen edge start", run, 1);

        // Abort mid-load and restart (R10)
        modes[0] = 3; modes[1] = 1;
        build(1);
        do_reset(1'b0, 1'b0);
        repeat (300) step(1'b0, 1'b0);
        do_reset(1'b0, 1'b1);
        chk(busy && rom_addr == 0 && ctl_sel && blk_addr == 0, "R10", "restart point",
            {rom_addr, ctl_sel}, 9'h001);
        repeat (4 * n_tr + 4) step(1'b0, 1'b1);

        // Fifteen slaves (R6 block walk to the top code)
        for (int i = 0; i < 16; i++) modes[i] = (i == 9) ? 1 : 0;
        build(15);
        do_reset(1'b0, 1'b1);
        repeat (4 * n_tr + 4) step(1'b0, 1'b1);
        chk(blk_addr == 4'hF && !busy, "R6", "final block", blk_addr, 15);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule